// File: doc/BRIEF.md
# Workspace Operand Address Generator

This block works out the effective memory address of one instruction operand for a processor that keeps its general registers in ordinary memory. The registers start at a workspace pointer, so register n lives at the workspace pointer plus 2n. Even a register-direct operand therefore resolves to a memory address. The block takes a 4-bit register number, a 2-bit addressing mode, a byte/word flag, the workspace pointer and the current program counter. It then runs the memory reads and writes that the mode needs. A single request/acknowledge port carries them: register reads, the extension-word fetch from the instruction stream, and the write-back of auto-incremented registers.

The caller pulses `start` with all operand inputs valid and holds them until `done`. When `done` rises, the block presents the effective address, the program counter after any extension fetch, and an estimate of the machine cycles the address calculation used. That estimate is a fixed base cost per mode plus a wait penalty for each memory access, chosen by the region of that access's address. Moving the operand data itself and decoding the instruction are left to other logic.

Top module: `ws_operand_agen`

## Requirements
- R1: Mode 0 (register direct) gives address wp + 2*reg modulo 65536, makes no memory request, and reports 0 cycles.
- R2: Mode 1 (register indirect) reads the word at wp + 2*reg and uses that word as the address. It reports 4 + pen(wp + 2*reg) cycles.
- R3: Mode 2 with register 0 fetches an extension word at pc and uses that word as the address. It reports 8 + pen(pc) + pen(extension) cycles, plus 2 for a byte operand.
- R4: Mode 2 with a nonzero register first fetches the extension word at pc, then reads the register word. The address is register word + extension modulo 65536. It reports 8 + pen(pc) + 2*pen(wp + 2*reg) cycles, plus 2 for a byte operand.
- R5: Mode 3 (auto-increment) uses the register word as the address. It then writes back, to the same register address, the register word plus 2 for a word operand or plus 1 for a byte operand, modulo 65536. It reports 8 cycles for words or 6 for bytes, plus 2*pen(wp + 2*reg).
- R6: The penalty pen(a) depends on address bits [15:13]. It is 0 for values 0 and 4, 2 for value 3, and 4 for every other value.
- R7: At most one memory request is active at a time. While `mem_req` is high and not acknowledged, `mem_addr`, `mem_we` and `mem_wdata` stay stable.
- R8: `done` is a single-cycle pulse. While it is high, `ea`, `cycles` and `pc_next` are valid. `pc_next` equals pc + 2 in mode 2 and pc in every other mode.
- R9: After reset, `done` and `mem_req` are low until a `start` is accepted.
- R10: Memory writes occur only in mode 3, and there is exactly one per operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one address calculation |
| reg_num | input | 4 | Register number |
| mode | input | 2 | Addressing mode 0..3 |
| byte_op | input | 1 | 1 = byte operand, 0 = word operand |
| wp | input | 16 | Workspace pointer |
| pc | input | 16 | Address of the next instruction-stream word |
| mem_req | output | 1 | Memory request active |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Request accepted this cycle |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address |
| cycles | output | 8 | Estimated cycles consumed |
| pc_next | output | 16 | Program counter after operand decode |

## Verification
Some properties are checked by assertions on every cycle:
- the request stays stable while it waits for an acknowledge;
- `done` is a single-cycle pulse;
- writes happen only in auto-increment mode;
- a write-back differs from the reported address by the operand size;
- register-direct mode stays off the memory port.

The arithmetic needs the bench's sweeps, which cover every mode, operand size and register number against several workspace and program-counter values. That arithmetic includes:
- the address formed in each mode;
- the region penalties summed into the cycle count;
- wraparound of the workspace offset, the indexed sum and the increment;
- the number of accesses in each mode.

// File: rtl/ws_operand_agen.sv
module ws_operand_agen #(
  parameter int AW      = 16,
  parameter int CW      = 8,
  parameter int PEN_MID = 2,
  parameter int PEN_FAR = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    reg_num,
  input  logic [1:0]    mode,
  input  logic          byte_op,
  input  logic [AW-1:0] wp,
  input  logic [AW-1:0] pc,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic [CW-1:0] cycles,
  output logic [AW-1:0] pc_next
);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RDREG, S_WRREG, S_FIN} state_t;

  state_t        st;
  logic [AW-1:0] ext_q, ea_q, pcn_q, wdata_q;
  logic [CW-1:0] cyc_q;
  logic [AW-1:0] reg_addr;

  function automatic logic [CW-1:0] pen(input logic [AW-1:0] a);
    case (a[AW-1:AW-3])
      3'd0, 3'd4: pen = '0;
      3'd3:       pen = CW'(PEN_MID);
      default:    pen = CW'(PEN_FAR);
    endcase
  endfunction

  assign reg_addr  = wp + AW'({reg_num, 1'b0});
  assign mem_req   = (st == S_FETCH) || (st == S_RDREG) || (st == S_WRREG);
  assign mem_we    = (st == S_WRREG);
  assign mem_addr  = (st == S_FETCH) ? pc : reg_addr;
  assign mem_wdata = wdata_q;
  assign done      = (st == S_FIN);
  assign ea        = ea_q;
  assign cycles    = cyc_q;
  assign pc_next   = pcn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ext_q   <= '0;
      ea_q    <= '0;
      pcn_q   <= '0;
      wdata_q <= '0;
      cyc_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          pcn_q <= (mode == 2'd2) ? pc + AW'(2) : pc;
          case (mode)
            2'd0: begin cyc_q <= '0; ea_q <= reg_addr; st <= S_FIN; end
            2'd1: begin cyc_q <= CW'(4); st <= S_RDREG; end
            2'd2: begin cyc_q <= byte_op ? CW'(10) : CW'(8); st <= S_FETCH; end
            default: begin cyc_q <= byte_op ? CW'(6) : CW'(8); st <= S_RDREG; end
          endcase
        end
        S_FETCH: if (mem_ack) begin
          ext_q <= mem_rdata;
          if (reg_num == 4'd0) begin
            ea_q  <= mem_rdata;
            cyc_q <= cyc_q + pen(pc) + pen(mem_rdata);
            st    <= S_FIN;
          end else begin
            cyc_q <= cyc_q + pen(pc);
            st    <= S_RDREG;
          end
        end
        S_RDREG: if (mem_ack) begin
          case (mode)
            2'd1: begin
              ea_q  <= mem_rdata;
              cyc_q <= cyc_q + pen(reg_addr);
              st    <= S_FIN;
            end
            2'd2: begin
              ea_q  <= mem_rdata + ext_q;
              cyc_q <= cyc_q + pen(reg_addr) + pen(reg_addr);
              st    <= S_FIN;
            end
            default: begin
              ea_q    <= mem_rdata;
              wdata_q <= mem_rdata + (byte_op ? AW'(1) : AW'(2));
              cyc_q   <= cyc_q + pen(reg_addr);
              st      <= S_WRREG;
            end
          endcase
        end
        S_WRREG: if (mem_ack) begin
          cyc_q <= cyc_q + pen(reg_addr);
          st    <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_WRITE_MODE3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mode == 2'd3); // R10
  AST_MODE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd0 && st != S_IDLE |-> !mem_req); // R1
  AST_WB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> (mem_wdata - ea_q) == (byte_op ? AW'(1) : AW'(2))); // R5

endmodule

// File: tb/ws_operand_agen_bench.sv
module ws_operand_agen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  reg_num = '0;
  logic [1:0]  mode = '0;
  logic        byte_op = 1'b0;
  logic [15:0] wp = '0, pc = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        done;
  logic [15:0] ea, pc_next;
  logic [7:0]  cycles;

  int checks = 0, errors = 0, ncyc = 0;
  int n_acc = 0, n_wr = 0, waitc = 0;
  logic [15:0] wr_addr, wr_data, prev_addr, prev_wdata;
  logic        prev_pend = 1'b0, prev_we;
  logic        ovr_en = 1'b0;
  logic [15:0] ovr_val = '0;

  always #5 clk = ~clk;

  ws_operand_agen u_ws_operand_agen (
    .clk(clk), .rst_n(rst_n), .start(start), .reg_num(reg_num), .mode(mode),
    .byte_op(byte_op), .wp(wp), .pc(pc), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .done(done), .ea(ea), .cycles(cycles), .pc_next(pc_next));

  function automatic logic [15:0] rd(input logic [15:0] a);
    rd = ovr_en ? ovr_val : ((a * 16'h9e37) ^ 16'h3c5a);
  endfunction

  function automatic int pen(input logic [15:0] a);
    case (a[15:13])
      3'd0, 3'd4: pen = 0;
      3'd3:       pen = 2;
      default:    pen = 4;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (mode=%0d reg=%0d byte=%0d wp=%h pc=%h)",
               tag, act, exp, mode, reg_num, byte_op, wp, pc);
    end
  endtask

  // memory model with wait states and request-stability monitor
  always @(negedge clk) begin
    ncyc++;
    if (prev_pend)
      chk(mem_req && mem_addr == prev_addr && mem_we == prev_we && mem_wdata == prev_wdata,
          "R7 request held", int'(mem_addr), int'(prev_addr));
    prev_pend  = 1'b0;
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (waitc == 0) begin
        mem_ack   = 1'b1;
        mem_rdata = rd(mem_addr);
        n_acc++;
        if (mem_we) begin n_wr++; wr_addr = mem_addr; wr_data = mem_wdata; end
        waitc = (n_acc + int'(mem_addr[3:0])) % 3;
      end else begin
        waitc--;
        prev_pend = 1'b1;
      end
    end
    prev_addr = mem_addr; prev_we = mem_we; prev_wdata = mem_wdata;
  end

  task automatic run_op(input logic [1:0] m, input logic [3:0] r, input logic b,
                        input logic [15:0] w, input logic [15:0] p);
    logic [15:0] ra, v, x, e_ea, e_pc;
    int e_cyc, e_acc, e_wr, to;
    bit got;
    mode = m; reg_num = r; byte_op = b; wp = w; pc = p;
    n_acc = 0; n_wr = 0;
    ra = w + {11'd0, r, 1'b0};
    e_pc = (m == 2'd2) ? p + 16'd2 : p;
    e_wr = 0;
    case (m)
      2'd0: begin e_ea = ra; e_cyc = 0; e_acc = 0; end
      2'd1: begin v = rd(ra); e_ea = v; e_cyc = 4 + pen(ra); e_acc = 1; end
      2'd2: begin
        x = rd(p);
        if (r == 4'd0) begin e_ea = x; e_cyc = 8 + pen(p) + pen(x) + (b ? 2 : 0); e_acc = 1; end
        else begin v = rd(ra); e_ea = v + x; e_cyc = 8 + pen(p) + 2*pen(ra) + (b ? 2 : 0); e_acc = 2; end
      end
      default: begin v = rd(ra); e_ea = v; e_cyc = (b ? 6 : 8) + 2*pen(ra); e_acc = 2; e_wr = 1; end
    endcase
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    got = 1'b0;
    for (int i = 0; i < 60 && !got; i++) begin
      if (done) got = 1'b1; else @(negedge clk);
    end
    to = got ? 0 : 1;
    chk(got, "R8 done timeout", to, 0);
    if (got) begin
      case (m)
        2'd0: chk(ea == e_ea && n_acc == 0, "R1 address/no access", int'(ea), int'(e_ea));
        2'd1: chk(ea == e_ea, "R2 address", int'(ea), int'(e_ea));
        2'd2: chk(ea == e_ea, r == 0 ? "R3 address" : "R4 address", int'(ea), int'(e_ea));
        default: chk(ea == e_ea, "R5 address", int'(ea), int'(e_ea));
      endcase
      chk(int'(cycles) == e_cyc, "R6 cycle count", int'(cycles), e_cyc);
      chk(pc_next == e_pc, "R8 pc_next", int'(pc_next), int'(e_pc));
      chk(n_acc == e_acc, "R7 access count", n_acc, e_acc);
      chk(n_wr == e_wr, "R10 write count", n_wr, e_wr);
      if (m == 2'd3 && n_wr == 1) begin
        chk(wr_addr == ra, "R5 writeback address", int'(wr_addr), int'(ra));
        chk(wr_data == v + (b ? 16'd1 : 16'd2), "R5 writeback data", int'(wr_data),
            int'(v + (b ? 16'd1 : 16'd2)));
      end
      @(negedge clk);
      chk(!done, "R8 done single pulse", int'(done), 0);
    end
  endtask

  initial begin
    logic [15:0] wps [4];
    logic [15:0] pcs [3];
    wps[0] = 16'h8300; wps[1] = 16'h6010; wps[2] = 16'hFFF0; wps[3] = 16'h2000;
    pcs[0] = 16'h0100; pcs[1] = 16'h7FFE; pcs[2] = 16'hA002;
    repeat (3) @(negedge clk);
    chk(!done && !mem_req, "R9 reset idle", int'({done, mem_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !mem_req, "R9 idle after reset", int'({done, mem_req}), 0);
    for (int wi = 0; wi < 4; wi++)
      for (int pi = 0; pi < 3; pi++)
        for (int m = 0; m < 4; m++)
          for (int b = 0; b < 2; b++)
            for (int r = 0; r < 16; r++)
              run_op(2'(m), 4'(r), 1'(b), wps[wi], pcs[pi]);
    // wraparound corners with forced memory contents
    ovr_en = 1'b1; ovr_val = 16'hFFFF;
    run_op(2'd3, 4'd5, 1'b0, 16'h8300, 16'h0100);  // R5 word wrap to 0001
    run_op(2'd3, 4'd5, 1'b1, 16'h8300, 16'h0100);  // R5 byte wrap to 0000
    run_op(2'd2, 4'd3, 1'b0, 16'h8300, 16'h0100);  // R4 sum wrap
    run_op(2'd2, 4'd0, 1'b1, 16'h8300, 16'h0100);  // R3 region 7 penalty
    ovr_val = 16'h6000;
    run_op(2'd2, 4'd0, 1'b0, 16'h0000, 16'h8000);  // R6 region 3 / region 4
    ovr_en = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (ncyc > 150000);
    checks++; errors++;
    $display("FAIL watchdog R8 actual=%0d expected=%0d", ncyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule